// File: doc/BRIEF.md
# Asynchronous Receive Packet Formatter

This block sits behind the receive side of a serial-bus link core. For each decoded asynchronous packet it stores a fixed sequence of 32-bit quadlets in an internal receive FIFO. The first quadlet is a token that carries the receive status, the speed code and the acknowledge code. The header quadlets come next. Payload quadlets follow only when the transaction code carries data. The host takes the quadlets out one at a time through a read strobe and a head-of-FIFO data output. It can see an empty flag and a sticky overflow flag.

The link core presents the whole header in parallel with a valid/ready handshake and gives the data-quadlet count with it. The payload then arrives one quadlet per beat on a second valid/ready handshake. Before it commits a packet, the formatter decides whether to keep it. It throws away requests that are aimed at the local agent and packets with transaction codes it does not handle. It also throws away any packet that would not fit in the free FIFO space. A packet it throws away still has its payload beats consumed, so the link core never stalls.

Top module: `arx_formatter`

## Requirements
- R1: After reset the FIFO is empty, the overflow flag is clear, `hdrReady` is high and `payReady` is low.
- R2: The first stored quadlet is the token: bits 31:28 receive status, bits 18:16 speed code, bits 3:0 acknowledge code, every other bit zero.
- R3: The second stored quadlet is destination ID in 31:16, transaction label in 15:10, retry code in 9:8, transaction code in 7:4, priority in 3:0.
- R4: For quadlet-format codes (0, 2, 4, 6) the third stored quadlet is source ID in 31:16, response code in 15:12, and zero in 11:0.
- R5: For block-format codes (1, 5, 7, 9, 11) the third stored quadlet is source ID in 31:16 with offset bits 47:32 in 15:0. The fourth stored quadlet is offset bits 31:0.
- R6: Payload is stored after the header as follows. Codes 0 and 6 store one data quadlet. Codes 1, 7, 9 and 11 store `hdrLen` data quadlets, and `hdrLen` may be zero. Codes 2, 4 and 5 store none and take no payload beats.
- R7: A request (codes 0, 1, 4, 5, 9) with `hdrForAgent` high is not stored, and its payload beats are consumed. A response (codes 2, 6, 7, 11) is stored whatever the value of `hdrForAgent`.
- R8: Packets with any other transaction code (3, 8, 10, 12 to 15) are not stored, and they do not set the overflow flag.
- R9: A packet is not stored, and its payload beats are still consumed, when it passes the R7/R8 filter but its quadlet count is larger than the free FIFO space. In that case `ovfFlag` is set. The flag stays set until `ovfClr`, and a new overflow wins over a clear in the same cycle. A packet that exactly fills the free space is stored.
- R10: `hostData` shows the oldest stored quadlet. Each `hostRd` cycle removes exactly one quadlet, in arrival order. A `hostRd` while the FIFO is empty is ignored.
- R11: `hdrReady` and `payReady` are never high together. Payload offered while the block waits for a header is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrValid | input | 1 | Header fields valid |
| hdrReady | output | 1 | Block accepts a header |
| hdrStat | input | 4 | Receive status for the token |
| hdrSpd | input | 3 | Speed code for the token |
| hdrAck | input | 4 | Acknowledge code for the token |
| hdrDst | input | 16 | Destination ID |
| hdrSrc | input | 16 | Source ID |
| hdrTLabel | input | 6 | Transaction label |
| hdrRt | input | 2 | Retry code |
| hdrTCode | input | 4 | Transaction code |
| hdrPri | input | 4 | Priority |
| hdrRCode | input | 4 | Response code (quadlet format) |
| hdrOffset | input | 48 | Destination offset (block format) |
| hdrLen | input | LEN_W | Data quadlet count (block format) |
| hdrForAgent | input | 1 | Packet is addressed to the local agent |
| payValid | input | 1 | Payload quadlet valid |
| payData | input | 32 | Payload quadlet |
| payReady | output | 1 | Block accepts a payload quadlet |
| hostRd | input | 1 | Host pops one quadlet |
| hostData | output | 32 | Oldest stored quadlet |
| fifoEmpty | output | 1 | FIFO holds no quadlet |
| ovfFlag | output | 1 | Sticky packet-dropped-for-space flag |
| ovfClr | input | 1 | Clears the overflow flag |

## Verification
The header is accepted at a clock edge. The token is written at the next edge, and each further header quadlet one edge later. Each payload quadlet is written at the same edge as its beat. `hdrReady` comes back one cycle after the last write, and the overflow flag changes at the accept edge. The bench keeps a behavioural queue of the quadlets it expects, together with the occupancy and the flag. It compares the queue with `fifoEmpty`, `hostData` and `ovfFlag` on every falling edge, but only while the block is idle, because at that point all writes from the last packet are complete. Reads pop both the FIFO and the queue at the same edge, and the head is compared before each pop.

// File: rtl/arx_pkg.sv
package arx_pkg;

  typedef enum logic [2:0] {
    SEL_TOKEN,
    SEL_DEST,
    SEL_SRC,
    SEL_OFFS,
    SEL_DATA
  } wordSel_t;

  typedef struct packed {
    logic     capture;
    logic     push;
    wordSel_t sel;
  } strobes_t;

  function automatic logic isBlockFmt(input logic [3:0] tc);
    return tc inside {4'd1, 4'd5, 4'd7, 4'd9, 4'd11};
  endfunction

  function automatic logic carriesData(input logic [3:0] tc);
    return tc inside {4'd0, 4'd1, 4'd6, 4'd7, 4'd9, 4'd11};
  endfunction

  function automatic logic isKnown(input logic [3:0] tc);
    return tc inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7, 4'd9, 4'd11};
  endfunction

  function automatic logic isRequest(input logic [3:0] tc);
    return tc inside {4'd0, 4'd1, 4'd4, 4'd5, 4'd9};
  endfunction

endpackage

// File: rtl/arx_ctrl.sv
module arx_ctrl
  import arx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int NEED_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hdrValid,
  input  logic [3:0]       hdrTCode,
  input  logic [LEN_W-1:0] hdrLen,
  input  logic             hdrForAgent,
  input  logic             payValid,
  input  logic             ovfClr,
  input  logic [CNT_W-1:0] freeWords,
  output logic             hdrReady,
  output logic             payReady,
  output logic             ovfFlag,
  output strobes_t         ctl
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_TOKEN, ST_DEST, ST_SRC, ST_OFFS, ST_DATA, ST_SKIP
  } state_t;

  state_t           state;
  logic [LEN_W-1:0] remain;
  logic             blkR;

  logic             blk;
  logic [LEN_W-1:0] dataWords;
  logic [NEED_W:0]  need;
  logic             reject;
  logic             noRoom;
  logic             accept;

  always_comb begin
    blk       = isBlockFmt(hdrTCode);
    dataWords = carriesData(hdrTCode) ? (blk ? hdrLen : LEN_W'(1)) : '0;
    need      = (blk ? (NEED_W+1)'(4) : (NEED_W+1)'(3)) + (NEED_W+1)'(dataWords);
    // R7, R8: filtering precedes the space check
    reject    = !isKnown(hdrTCode) || (isRequest(hdrTCode) && hdrForAgent);
    noRoom    = 32'(need) > 32'(freeWords);
    accept    = hdrValid && hdrReady;
  end

  assign hdrReady = (state == ST_IDLE);
  assign payReady = (state == ST_DATA) || (state == ST_SKIP);

  always_comb begin
    ctl.capture = accept && !reject && !noRoom;
    ctl.push    = 1'b0;
    ctl.sel     = SEL_TOKEN;
    unique case (state)
      ST_TOKEN: begin ctl.push = 1'b1; ctl.sel = SEL_TOKEN; end
      ST_DEST:  begin ctl.push = 1'b1; ctl.sel = SEL_DEST;  end
      ST_SRC:   begin ctl.push = 1'b1; ctl.sel = SEL_SRC;   end
      ST_OFFS:  begin ctl.push = 1'b1; ctl.sel = SEL_OFFS;  end
      ST_DATA:  begin ctl.push = payValid; ctl.sel = SEL_DATA; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      remain  <= '0;
      blkR    <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      if (ovfClr) ovfFlag <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          remain <= dataWords;
          blkR   <= blk;
          if (reject || noRoom) begin
            if (!reject) ovfFlag <= 1'b1;  // R9: set wins over clear
            if (dataWords != '0) state <= ST_SKIP;
          end else begin
            state <= ST_TOKEN;
          end
        end
        ST_TOKEN: state <= ST_DEST;
        ST_DEST:  state <= ST_SRC;
        ST_SRC:   state <= blkR ? ST_OFFS : ((remain != '0) ? ST_DATA : ST_IDLE);
        ST_OFFS:  state <= (remain != '0) ? ST_DATA : ST_IDLE;
        ST_DATA, ST_SKIP: if (payValid) begin
          remain <= remain - LEN_W'(1);
          if (remain == LEN_W'(1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/arx_dpath.sv
module arx_dpath
  import arx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         ctl,
  input  logic [3:0]       hdrStat,
  input  logic [2:0]       hdrSpd,
  input  logic [3:0]       hdrAck,
  input  logic [15:0]      hdrDst,
  input  logic [15:0]      hdrSrc,
  input  logic [5:0]       hdrTLabel,
  input  logic [1:0]       hdrRt,
  input  logic [3:0]       hdrTCode,
  input  logic [3:0]       hdrPri,
  input  logic [3:0]       hdrRCode,
  input  logic [47:0]      hdrOffset,
  input  logic [31:0]      payData,
  input  logic             hostRd,
  output logic [31:0]      hostData,
  output logic             fifoEmpty,
  output logic [CNT_W-1:0] freeWords
);

  logic [3:0]  statR, tcR, priR, rcR, ackR;
  logic [2:0]  spdR;
  logic [15:0] dstR, srcR;
  logic [5:0]  tlR;
  logic [1:0]  rtR;
  logic [47:0] offR;
  logic [31:0] word;

  logic [31:0]      mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             pop;

  always_ff @(posedge clk) begin
    if (ctl.capture) begin
      statR <= hdrStat; spdR <= hdrSpd; ackR <= hdrAck;
      dstR  <= hdrDst;  srcR <= hdrSrc; tlR  <= hdrTLabel;
      rtR   <= hdrRt;   tcR  <= hdrTCode; priR <= hdrPri;
      rcR   <= hdrRCode; offR <= hdrOffset;
    end
  end

  always_comb begin
    unique case (ctl.sel)
      SEL_TOKEN: word = {statR, 9'h0, spdR, 12'h0, ackR};          // R2
      SEL_DEST:  word = {dstR, tlR, rtR, tcR, priR};               // R3
      SEL_SRC:   word = isBlockFmt(tcR) ? {srcR, offR[47:32]}      // R5
                                        : {srcR, rcR, 12'h0};      // R4
      SEL_OFFS:  word = offR[31:0];
      default:   word = payData;
    endcase
  end

  assign pop       = hostRd && (count != '0);   // R10
  assign fifoEmpty = (count == '0);
  assign freeWords = CNT_W'(DEPTH) - count;
  assign hostData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (ctl.push) mem[wrPtr] <= word;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (ctl.push) wrPtr <= wrPtr + AW'(1);
      if (pop)      rdPtr <= rdPtr + AW'(1);
      unique case ({ctl.push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/arx_formatter.sv
module arx_formatter
  import arx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hdrValid,
  output logic             hdrReady,
  input  logic [3:0]       hdrStat,
  input  logic [2:0]       hdrSpd,
  input  logic [3:0]       hdrAck,
  input  logic [15:0]      hdrDst,
  input  logic [15:0]      hdrSrc,
  input  logic [5:0]       hdrTLabel,
  input  logic [1:0]       hdrRt,
  input  logic [3:0]       hdrTCode,
  input  logic [3:0]       hdrPri,
  input  logic [3:0]       hdrRCode,
  input  logic [47:0]      hdrOffset,
  input  logic [LEN_W-1:0] hdrLen,
  input  logic             hdrForAgent,
  input  logic             payValid,
  input  logic [31:0]      payData,
  output logic             payReady,
  input  logic             hostRd,
  output logic [31:0]      hostData,
  output logic             fifoEmpty,
  output logic             ovfFlag,
  input  logic             ovfClr
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  strobes_t         ctl;
  logic [CNT_W-1:0] freeWords;

  arx_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) iCtrl (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrTCode(hdrTCode),
    .hdrLen(hdrLen), .hdrForAgent(hdrForAgent), .payValid(payValid),
    .ovfClr(ovfClr), .freeWords(freeWords), .hdrReady(hdrReady),
    .payReady(payReady), .ovfFlag(ovfFlag), .ctl(ctl)
  );

  arx_dpath #(.DEPTH(DEPTH)) iDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hdrStat(hdrStat), .hdrSpd(hdrSpd),
    .hdrAck(hdrAck), .hdrDst(hdrDst), .hdrSrc(hdrSrc), .hdrTLabel(hdrTLabel),
    .hdrRt(hdrRt), .hdrTCode(hdrTCode), .hdrPri(hdrPri), .hdrRCode(hdrRCode),
    .hdrOffset(hdrOffset), .payData(payData), .hostRd(hostRd),
    .hostData(hostData), .fifoEmpty(fifoEmpty), .freeWords(freeWords)
  );

endmodule

// File: rtl/arx_checker.sv
module arx_checker (
  input logic clk,
  input logic rstN,
  input logic hdrValid,
  input logic hdrReady,
  input logic payReady,
  input logic ovfFlag,
  input logic ovfClr,
  input logic fifoEmpty,
  input logic hostRd,
  input logic push
);

  p_phase_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(hdrReady && payReady));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag && !ovfClr |=> ovfFlag);

  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(hdrValid && hdrReady));

  p_empty_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty && hostRd && !push |=> fifoEmpty);

  p_push_fills_r10: assert property (@(posedge clk) disable iff (!rstN)
    push |=> !fifoEmpty);

endmodule

bind arx_formatter arx_checker iChk (
  .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrReady(hdrReady),
  .payReady(payReady), .ovfFlag(ovfFlag), .ovfClr(ovfClr),
  .fifoEmpty(fifoEmpty), .hostRd(hostRd), .push(ctl.push)
);

// File: tb/test_arx_formatter.sv
module test_arx_formatter;

  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hdrValid = 1'b0, hdrReady;
  logic [3:0] hdrStat = '0, hdrAck = '0, hdrTCode = '0, hdrPri = '0, hdrRCode = '0;
  logic [2:0] hdrSpd = '0;
  logic [15:0] hdrDst = '0, hdrSrc = '0;
  logic [5:0] hdrTLabel = '0;
  logic [1:0] hdrRt = '0;
  logic [47:0] hdrOffset = '0;
  logic [LEN_W-1:0] hdrLen = '0;
  logic hdrForAgent = 1'b0;
  logic payValid = 1'b0, payReady;
  logic [31:0] payData = '0;
  logic hostRd = 1'b0;
  logic [31:0] hostData;
  logic fifoEmpty, ovfFlag;
  logic ovfClr = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string tagQ[$];
  bit ovfM = 1'b0;
  bit settled = 1'b0;
  int cycles = 0;

  always #(CLK_P/2) clk = ~clk;

  arx_formatter #(.DEPTH(DEPTH), .LEN_W(LEN_W)) i_arx_formatter (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrReady(hdrReady),
    .hdrStat(hdrStat), .hdrSpd(hdrSpd), .hdrAck(hdrAck), .hdrDst(hdrDst),
    .hdrSrc(hdrSrc), .hdrTLabel(hdrTLabel), .hdrRt(hdrRt), .hdrTCode(hdrTCode),
    .hdrPri(hdrPri), .hdrRCode(hdrRCode), .hdrOffset(hdrOffset), .hdrLen(hdrLen),
    .hdrForAgent(hdrForAgent), .payValid(payValid), .payData(payData),
    .payReady(payReady), .hostRd(hostRd), .hostData(hostData),
    .fifoEmpty(fifoEmpty), .ovfFlag(ovfFlag), .ovfClr(ovfClr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=50000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // per-clock comparison against the behavioural queue while idle
  always @(negedge clk) begin
    #1;
    if (settled && rstN) begin
      chk(fifoEmpty == (expQ.size() == 0), "R10 empty flag", 32'(fifoEmpty),
          32'(expQ.size() == 0));
      chk(ovfFlag == ovfM, "R9 overflow flag", 32'(ovfFlag), 32'(ovfM));
      chk(!(hdrReady && payReady), "R11 ready exclusive",
          {30'h0, hdrReady, payReady}, 32'h2);
      if (expQ.size() != 0)
        chk(hostData == expQ[0], {tagQ[0], " head"}, hostData, expQ[0]);
    end
  end

  function automatic bit mBlock(input logic [3:0] tc);
    case (tc) 4'd1, 4'd5, 4'd7, 4'd9, 4'd11: return 1'b1; default: return 1'b0; endcase
  endfunction

  function automatic bit mData(input logic [3:0] tc);
    case (tc) 4'd0, 4'd1, 4'd6, 4'd7, 4'd9, 4'd11: return 1'b1; default: return 1'b0; endcase
  endfunction

  function automatic bit mKnown(input logic [3:0] tc);
    case (tc) 4'd3, 4'd8, 4'd10, 4'd12, 4'd13, 4'd14, 4'd15: return 1'b0;
      default: return 1'b1; endcase
  endfunction

  function automatic bit mReq(input logic [3:0] tc);
    case (tc) 4'd0, 4'd1, 4'd4, 4'd5, 4'd9: return 1'b1; default: return 1'b0; endcase
  endfunction

  task automatic sendPkt(input logic [3:0] tc, input int len, input bit agent,
                         input int k, input string tag);
    int nData;
    int need;
    bit keep;
    logic [31:0] dw [$];
    settled = 1'b0;
    hdrStat = 4'(k + 3); hdrSpd = 3'(k + 1); hdrAck = 4'(k + 5);
    hdrDst = 16'hFFC0 ^ 16'(k); hdrSrc = 16'h1230 + 16'(k);
    hdrTLabel = 6'(k * 7); hdrRt = 2'(k); hdrTCode = tc; hdrPri = 4'(k + 9);
    hdrRCode = 4'(k + 2); hdrOffset = 48'hFEDC_0000_0000 + 48'(k * 32'h01010104);
    hdrLen = LEN_W'(len); hdrForAgent = agent;
    nData = mData(tc) ? (mBlock(tc) ? len : 1) : 0;
    need = (mBlock(tc) ? 4 : 3) + nData;
    keep = 1'b1;
    if (!mKnown(tc) || (mReq(tc) && agent)) keep = 1'b0;
    else if (need > DEPTH - expQ.size()) begin keep = 1'b0; ovfM = 1'b1; end
    hdrValid = 1'b1;
    while (!hdrReady) @(negedge clk);
    @(negedge clk);
    hdrValid = 1'b0;
    for (int i = 0; i < nData; i++) begin
      payValid = 1'b1;
      payData = {16'(k), 16'(i)};
      dw.push_back(payData);
      while (!payReady) @(negedge clk);
      @(negedge clk);
    end
    payValid = 1'b0;
    while (!hdrReady) @(negedge clk);
    if (keep) begin
      expQ.push_back({hdrStat, 9'h0, hdrSpd, 12'h0, hdrAck}); tagQ.push_back({"R2 ", tag});
      expQ.push_back({hdrDst, hdrTLabel, hdrRt, tc, hdrPri}); tagQ.push_back({"R3 ", tag});
      if (mBlock(tc)) begin
        expQ.push_back({hdrSrc, hdrOffset[47:32]}); tagQ.push_back({"R5 ", tag});
        expQ.push_back(hdrOffset[31:0]); tagQ.push_back({"R5 ", tag});
      end else begin
        expQ.push_back({hdrSrc, hdrRCode, 12'h0}); tagQ.push_back({"R4 ", tag});
      end
      foreach (dw[j]) begin expQ.push_back(dw[j]); tagQ.push_back({"R6 ", tag}); end
    end
    settled = 1'b1;
  endtask

  task automatic drain();
    while (expQ.size() != 0) begin
      chk(hostData == expQ[0], {tagQ[0], " R10 read"}, hostData, expQ[0]);
      hostRd = 1'b1;
      @(negedge clk);
      hostRd = 1'b0;
      void'(expQ.pop_front());
      void'(tagQ.pop_front());
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(fifoEmpty == 1'b1, "R1 empty", 32'(fifoEmpty), 1);
    chk(ovfFlag == 1'b0, "R1 overflow", 32'(ovfFlag), 0);
    chk(hdrReady == 1'b1, "R1 hdrReady", 32'(hdrReady), 1);
    chk(payReady == 1'b0, "R1 payReady", 32'(payReady), 0);
    settled = 1'b1;

    // R11: payload offered while waiting for a header is ignored
    payValid = 1'b1; payData = 32'hDEAD_BEEF;
    repeat (4) @(negedge clk);
    payValid = 1'b0;
    chk(fifoEmpty == 1'b1, "R11 idle payload ignored", 32'(fifoEmpty), 1);

    // R10: read on empty ignored
    hostRd = 1'b1; @(negedge clk); hostRd = 1'b0;
    chk(fifoEmpty == 1'b1, "R10 empty read", 32'(fifoEmpty), 1);

    sendPkt(4'd0, 0, 1'b0, 1, "wr quad req");       drain();
    sendPkt(4'd4, 0, 1'b0, 2, "rd quad req");       drain();
    sendPkt(4'd2, 0, 1'b0, 3, "wr resp");           drain();
    sendPkt(4'd6, 0, 1'b1, 4, "rd quad resp R7");   drain();
    sendPkt(4'd1, 3, 1'b0, 5, "wr blk req");        drain();
    sendPkt(4'd5, 6, 1'b0, 6, "rd blk req");        drain();
    sendPkt(4'd7, 0, 1'b0, 7, "rd blk resp len0");  drain();
    sendPkt(4'd11, 2, 1'b1, 8, "lock resp R7");     drain();

    // R7 agent-addressed requests dropped, payload consumed
    sendPkt(4'd1, 2, 1'b1, 9, "R7 blk req agent");
    chk(fifoEmpty == 1'b1, "R7 dropped", 32'(fifoEmpty), 1);
    sendPkt(4'd0, 0, 1'b1, 10, "R7 quad req agent");
    chk(fifoEmpty == 1'b1, "R7 dropped quad", 32'(fifoEmpty), 1);
    // R8 unknown codes
    sendPkt(4'd8, 0, 1'b0, 11, "R8 code 8");
    sendPkt(4'd14, 0, 1'b0, 12, "R8 code 14");
    chk(fifoEmpty == 1'b1 && ovfFlag == 1'b0, "R8 dropped",
        {30'h0, fifoEmpty, ovfFlag}, 32'h2);

    // R9 overflow and exact fit
    sendPkt(4'd1, 9, 1'b0, 13, "fill");             // 13 of 16
    sendPkt(4'd0, 0, 1'b0, 14, "R9 no room");       // needs 4, free 3
    chk(ovfFlag == 1'b1, "R9 set", 32'(ovfFlag), 1);
    sendPkt(4'd2, 0, 1'b0, 15, "R9 exact fit");     // needs 3
    chk(expQ.size() == DEPTH, "R9 exact fit stored", 32'(expQ.size()), DEPTH);
    sendPkt(4'd4, 0, 1'b0, 16, "R9 full");
    ovfClr = 1'b1; @(negedge clk); ovfClr = 1'b0; ovfM = 1'b0;
    chk(ovfFlag == 1'b0, "R9 cleared", 32'(ovfFlag), 0);
    drain();
    sendPkt(4'd9, 1, 1'b0, 17, "lock req after drain"); drain();

    settled = 1'b0;
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule